// File: doc/BRIEF.md
# Streaming Core Dataflow Controller

This block is a small control state machine placed between an input word FIFO, a streaming compute core and an output word FIFO. It forwards each input word to the core when the core can take it, forwards each finished core result to the output FIFO, and gates the core's clock enable and start inputs. When the output FIFO cannot accept data, the whole core is frozen, so no result can be lost downstream.

All strobes and the clock enable are combinational decisions taken from the current state and the live handshake inputs. A word is therefore moved in the same cycle in which its conditions hold. The state register only records the operating phase: idle, reading, reading and writing, writing, or stalled. In a cycle where both sides are able to move, one input word and one output word are moved together. Data words pass straight through the controller without being stored.

Top module: `stream_core_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. After any cycle with `rst` high, the controller is idle, and in that first idle cycle `in_pop` and `out_wr` are both low whatever the inputs are.
- R2: While idle, `core_ce` and `core_start` are high exactly when `in_avail` and `out_rdy` are both high. No word is moved in that cycle, and the next state is the reading state.
- R3: In a running state with `out_rdy` high, `in_pop` and `core_din_vld` are high in the same cycle whenever `in_avail` and `core_rfd` are high and `core_done` is low. In that cycle `core_din` equals `in_data`.
- R4: In a running state with `out_rdy` high and `core_dv` high, `out_wr` is high in that cycle and `out_data` equals `core_dout`.
- R5: When the conditions of R3 and R4 hold in the same cycle, one word is read and one word is written in that single cycle.
- R6: Whenever `out_rdy` is low, `core_ce`, `core_start`, `in_pop` and `out_wr` are all low, and a running controller moves to the stalled state.
- R7: In the stalled state, `core_ce` and `core_start` go high again in the first cycle in which `out_rdy` is high.
- R8: In the writing state, if `core_dv` is low while `out_rdy` is high, `core_ce` and `core_start` are low in that cycle and the controller returns to idle.
- R9: No input word is taken while `in_avail` is low or `core_done` is high.
- R10: Under random back-pressure and random core readiness, the output word sequence equals the core function applied to the input word sequence, with no word dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Head word of the input FIFO |
| in_avail | input | 1 | Input FIFO not empty |
| in_pop | output | 1 | Input FIFO read strobe |
| core_din | output | DATA_W | Word presented to the core |
| core_din_vld | output | 1 | Core input enable (one word accepted) |
| core_rfd | input | 1 | Core ready for data |
| core_done | input | 1 | Core will take no more input |
| core_dout | input | DATA_W | Core result word |
| core_dv | input | 1 | Core result valid |
| core_ce | output | 1 | Core clock enable |
| core_start | output | 1 | Core start |
| out_data | output | DATA_W | Word written to the output FIFO |
| out_wr | output | 1 | Output FIFO write strobe |
| out_rdy | input | 1 | Output FIFO can accept a word |

## Verification
Every strobe and `core_ce` is due in the same cycle as the inputs that cause it, and a state change shows up after one rising edge. The directed part of the bench drives inputs on the falling edge and samples the outputs 1 ns later. This places each check in the cycle the requirement names, and the effect of a state change is read one full cycle after the stimulus. In the streaming part, a bench core model registers a result one enabled edge after it takes a word. The scoreboard compares the output word at each rising edge where `out_wr` is high against the head of the expected queue, so results are never checked against a fixed latency.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [2:0] {
      SC_IDLE  = 3'd0,
      SC_READ  = 3'd1,
      SC_RDWR  = 3'd2,
      SC_WRITE = 3'd3,
      SC_STALL = 3'd4
   } sc_state_e;

   localparam int SC_NSTATES = 5;

endpackage

// File: rtl/sc_decide.sv
module sc_decide
   import sc_pkg::*;
(
   input  sc_state_e state,
   input  logic      in_avail,
   input  logic      core_rfd,
   input  logic      core_done,
   input  logic      core_dv,
   input  logic      out_rdy,
   output logic      ce,
   output logic      rd_fire,
   output logic      wr_fire,
   output sc_state_e nxt
);

   logic can_rd;
   assign can_rd = in_avail & core_rfd & ~core_done;

   always_comb begin
      ce      = 1'b0;
      rd_fire = 1'b0;
      wr_fire = 1'b0;
      nxt     = state;
      case (state)
         SC_IDLE: begin
            if (in_avail && out_rdy) begin
               ce  = 1'b1;
               nxt = SC_READ;
            end
         end
         default: begin
            if (!out_rdy) begin
               nxt = SC_STALL;
            end else if (state == SC_WRITE && !core_dv) begin
               nxt = SC_IDLE;
            end else begin
               ce      = 1'b1;
               rd_fire = can_rd;
               wr_fire = core_dv;
               if (can_rd && core_dv)  nxt = SC_RDWR;
               else if (core_dv)       nxt = SC_WRITE;
               else                    nxt = SC_READ;
            end
         end
      endcase
   end

endmodule

// File: rtl/sc_state_reg.sv
module sc_state_reg
   import sc_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
)(
   input  logic      clk,
   input  logic      rst,
   input  sc_state_e nxt,
   output sc_state_e cur
);

   localparam int NS = SC_NSTATES;

   generate
      if (ONEHOT) begin : g_onehot
         logic [NS-1:0] oh_q;
         always_ff @(posedge clk) begin
            if (rst) oh_q <= NS'(1) << int'(SC_IDLE);
            else     oh_q <= NS'(1) << int'(nxt);
         end
         always_comb begin
            cur = SC_IDLE;
            for (int i = 0; i < NS; i++) begin
               if (oh_q[i]) cur = sc_state_e'(3'(i));
            end
         end
      end else begin : g_binary
         sc_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= SC_IDLE;
            else     st_q <= nxt;
         end
         assign cur = st_q;
      end
   endgenerate

endmodule

// File: rtl/stream_core_ctrl.sv
module stream_core_ctrl
   import sc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit ONEHOT = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_avail,
   output logic              in_pop,
   output logic [DATA_W-1:0] core_din,
   output logic              core_din_vld,
   input  logic              core_rfd,
   input  logic              core_done,
   input  logic [DATA_W-1:0] core_dout,
   input  logic              core_dv,
   output logic              core_ce,
   output logic              core_start,
   output logic [DATA_W-1:0] out_data,
   output logic              out_wr,
   input  logic              out_rdy
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("stream_core_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   sc_state_e state;
   sc_state_e nxt;
   logic      ce, rd_fire, wr_fire;

   sc_decide u_decide (
      .state     (state),
      .in_avail  (in_avail),
      .core_rfd  (core_rfd),
      .core_done (core_done),
      .core_dv   (core_dv),
      .out_rdy   (out_rdy),
      .ce        (ce),
      .rd_fire   (rd_fire),
      .wr_fire   (wr_fire),
      .nxt       (nxt)
   );

   sc_state_reg #(.ONEHOT(ONEHOT)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (state)
   );

   assign core_ce      = ce;
   assign core_start   = ce;
   assign in_pop       = rd_fire;
   assign core_din_vld = rd_fire;
   assign core_din     = in_data;
   assign out_wr       = wr_fire;
   assign out_data     = core_dout;

endmodule

// File: rtl/sc_ctrl_checker.sv
module sc_ctrl_checker
   import sc_pkg::*;
(
   input logic      clk,
   input logic      rst,
   input logic      in_avail,
   input logic      core_rfd,
   input logic      core_done,
   input logic      core_dv,
   input logic      out_rdy,
   input logic      core_ce,
   input logic      core_start,
   input logic      in_pop,
   input logic      out_wr,
   input sc_state_e state
);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!in_pop && !out_wr)); // R1

   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
      (state == SC_IDLE && in_avail && out_rdy) |=> (state == SC_READ)); // R2

   AST_POP_LEGAL: assert property (@(posedge clk) disable iff (rst)
      in_pop |-> (in_avail && core_rfd && !core_done && core_ce)); // R3

   AST_WR_LEGAL: assert property (@(posedge clk) disable iff (rst)
      out_wr |-> (core_dv && core_ce)); // R4

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !out_rdy |-> (!core_ce && !core_start && !in_pop && !out_wr)); // R6

   AST_STALL_RESUME: assert property (@(posedge clk) disable iff (rst)
      (state == SC_STALL && out_rdy) |-> (core_ce && core_start)); // R7

   AST_DV_DROP: assert property (@(posedge clk) disable iff (rst)
      (state == SC_WRITE && out_rdy && !core_dv) |=> (state == SC_IDLE)); // R8

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!in_avail || core_done) |-> !in_pop); // R9

endmodule

bind stream_core_ctrl sc_ctrl_checker u_sc_chk (
   .clk        (clk),
   .rst        (rst),
   .in_avail   (in_avail),
   .core_rfd   (core_rfd),
   .core_done  (core_done),
   .core_dv    (core_dv),
   .out_rdy    (out_rdy),
   .core_ce    (core_ce),
   .core_start (core_start),
   .in_pop     (in_pop),
   .out_wr     (out_wr),
   .state      (state)
);

// File: tb/stream_core_ctrl_bench.sv
`timescale 1ns/1ps
module stream_core_ctrl_bench;

   localparam int DW    = 32;
   localparam int NWORD = 300;

   logic          clk = 1'b0;
   logic          rst;
   logic [DW-1:0] in_data;
   logic          in_avail;
   logic          in_pop;
   logic [DW-1:0] core_din;
   logic          core_din_vld;
   logic          core_rfd;
   logic          core_done;
   logic [DW-1:0] core_dout;
   logic          core_dv;
   logic          core_ce;
   logic          core_start;
   logic [DW-1:0] out_data;
   logic          out_wr;
   logic          out_rdy;

   logic          model_on;
   logic          d_dv;
   logic [DW-1:0] d_dout;
   logic          m_v;
   logic [DW-1:0] m_q;

   int checks = 0;
   int fails  = 0;
   int matched = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] in_q[$];

   always #2.5 clk = ~clk;

   assign core_dv   = model_on ? m_v : d_dv;
   assign core_dout = model_on ? m_q : d_dout;

   stream_core_ctrl #(.DATA_W(DW)) u_stream_core_ctrl (
      .clk(clk), .rst(rst), .in_data(in_data), .in_avail(in_avail),
      .in_pop(in_pop), .core_din(core_din), .core_din_vld(core_din_vld),
      .core_rfd(core_rfd), .core_done(core_done), .core_dout(core_dout),
      .core_dv(core_dv), .core_ce(core_ce), .core_start(core_start),
      .out_data(out_data), .out_wr(out_wr), .out_rdy(out_rdy)
   );

   function automatic logic [DW-1:0] core_fn(input logic [DW-1:0] x);
      return x * 32'd3 + 32'h1357;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // core model: one result register, advances only under clock enable
   always @(posedge clk) begin
      if (rst) m_v <= 1'b0;
      else if (model_on && core_ce) begin
         if (core_din_vld) begin
            m_q <= core_fn(core_din);
            m_v <= 1'b1;
         end else if (out_wr) begin
            m_v <= 1'b0;
         end
      end
   end

   // scoreboard monitor (R10)
   always @(posedge clk) begin
      if (model_on && !rst && out_wr) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected word", out_data, '0);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            check(out_data == e, "R10 output order", out_data, e);
            matched++;
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", matched, NWORD);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      int sent;
      rst = 1'b1; model_on = 1'b0; in_avail = 1'b0; in_data = '0;
      core_rfd = 1'b1; core_done = 1'b0; d_dv = 1'b0; d_dout = '0; out_rdy = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      #1;
      check(!core_ce && !core_start && !in_pop && !out_wr, "R1 reset idle",
            {28'd0, core_ce, core_start, in_pop, out_wr}, '0);

      // wake from idle
      in_avail = 1'b1; in_data = 32'hA5A5_0001;
      #1;
      check(core_ce && core_start, "R2 idle wake ce/start", {31'd0, core_ce}, 1);
      check(!in_pop && !out_wr, "R2 idle no transfer", {31'd0, in_pop}, 0);

      // READ state: read fires
      @(negedge clk); #1;
      check(in_pop && core_din_vld, "R3 read strobe", {31'd0, in_pop}, 1);
      check(core_din == 32'hA5A5_0001, "R3 forwarded word", core_din, 32'hA5A5_0001);

      // combined read and write
      @(negedge clk);
      in_data = 32'hA5A5_0002; d_dv = 1'b1; d_dout = 32'hBEEF_0001;
      #1;
      check(in_pop && out_wr, "R5 read and write same cycle",
            {30'd0, in_pop, out_wr}, 3);
      check(out_data == 32'hBEEF_0001, "R4 output word", out_data, 32'hBEEF_0001);

      // input empty, write only
      @(negedge clk);
      in_avail = 1'b0; d_dout = 32'hBEEF_0002;
      #1;
      check(out_wr && out_data == 32'hBEEF_0002, "R4 write only", out_data, 32'hBEEF_0002);
      check(!in_pop, "R9 no pop when empty", {31'd0, in_pop}, 0);

      // back-pressure
      @(negedge clk);
      out_rdy = 1'b0; in_avail = 1'b1;
      #1;
      check(!core_ce && !core_start && !out_wr && !in_pop, "R6 stall freeze",
            {28'd0, core_ce, core_start, in_pop, out_wr}, '0);
      @(negedge clk); #1;
      check(!core_ce && !out_wr, "R6 stall held", {31'd0, core_ce}, 0);

      // resume; core done blocks input
      @(negedge clk);
      out_rdy = 1'b1; d_dv = 1'b0; core_done = 1'b1;
      #1;
      check(core_ce && core_start, "R7 resume ce/start", {31'd0, core_ce}, 1);
      check(!in_pop, "R9 no pop when core done", {31'd0, in_pop}, 0);

      // READ -> WRITE
      @(negedge clk);
      core_done = 1'b0; in_avail = 1'b0; d_dv = 1'b1; d_dout = 32'hBEEF_0003;
      #1;
      check(out_wr && out_data == 32'hBEEF_0003, "R4 write from read state",
            out_data, 32'hBEEF_0003);

      // WRITE with valid dropped
      @(negedge clk);
      d_dv = 1'b0;
      #1;
      check(!core_ce && !core_start, "R8 valid drop gates ce", {31'd0, core_ce}, 0);

      // now idle: no transfer even with data
      @(negedge clk);
      in_avail = 1'b1;
      #1;
      check(!in_pop && core_ce, "R8 returned to idle", {30'd0, in_pop, core_ce}, 1);

      // reset while running
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      #1;
      check(!in_pop && !out_wr, "R1 reset mid-run", {30'd0, in_pop, out_wr}, 0);

      // streaming phase with scoreboard
      @(negedge clk);
      rst = 1'b1; in_avail = 1'b0; d_dv = 1'b0;
      @(negedge clk);
      rst = 1'b0; model_on = 1'b1;
      lfsr = 16'hACE1; sent = 0;
      while (sent < NWORD || in_q.size() != 0 || exp_q.size() != 0) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (sent < NWORD && lfsr[3]) begin
            logic [DW-1:0] w;
            w = {lfsr, 16'(sent)};
            in_q.push_back(w);
            exp_q.push_back(core_fn(w));
            sent++;
         end
         out_rdy  = lfsr[0] | lfsr[1];
         core_rfd = lfsr[5] | lfsr[7];
         in_avail = in_q.size() != 0;
         in_data  = (in_q.size() != 0) ? in_q[0] : '0;
         @(posedge clk);
         if (in_pop) void'(in_q.pop_front());
      end
      @(negedge clk);
      check(matched == NWORD, "R10 word count", matched, NWORD);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule